// File: doc/BRIEF.md
# Two-Wide Register Rename Table

This block sits behind a front end that hands over up to two decoded instructions per clock. Each instruction names one destination register and two source registers. The block replaces every architectural register number with a temporary designator. Sources take the designator currently mapped to their register. Each instruction that writes a register is given a fresh designator, which is then recorded in the map. Slot 0 carries the older instruction of the pair and slot 1 the younger.

Fresh designators come from a pointer that only counts upward, starting at a configurable first value. Retirement never returns designators to the pool. Once too few remain for a pair, the block lowers its ready output and holds that pair back. A pair is accepted on a rising edge where valid and ready are both high. Its renamed form appears on registered outputs one cycle later.

Top module: `rename2_top`

## Requirements
- R1: After reset, out_valid is low, in_ready is high for any pair, the allocation pointer holds FIRST_TAG, and the map sends every register i to the value i, so sources read before any write return their own register number.
- R2: A pair accepted on an edge appears on the r0_*/r1_* outputs with out_valid high during the following cycle; after any edge with no acceptance, out_valid is low.
- R3: A slot "writes" when its valid and write flags are both 1. The older writing slot gets the current pointer value and the younger writing slot gets the next value. The pointer then advances by the number of writing slots, so successive accepted pairs receive consecutive designators.
- R4: Each renamed source equals the designator that all earlier accepted pairs left mapped to that register.
- R5: A slot 1 source that names the register a writing slot 0 targets in the same pair gets slot 0's new designator.
- R6: When both slots of a pair write the same register, later readers of that register see slot 1's designator.
- R7: A slot that is invalid or has write flag 0 consumes no designator and leaves the pointer unchanged. Its r*_wr output is 0 and its r*_tag output is 0. A pair with no writing slot is always ready.
- R8: When the designators left (TAG_COUNT minus pointer) are fewer than the pair's writing slots, in_ready is low. The pair is not accepted, and the map and pointer stay unchanged.
- R9: While in_valid is low, the map, the pointer and the outputs' valid flag do not change state (out_valid stays low).
- R10: A source that names its own instruction's destination sees the mapping in force before that instruction, never the designator it is being given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pair on the inputs is offered |
| in_ready | output | 1 | Enough designators remain for the offered pair |
| s0_vld | input | 1 | Slot 0 holds an instruction |
| s0_wr | input | 1 | Slot 0 writes a destination |
| s0_dst | input | AW | Slot 0 destination register |
| s0_rs1 | input | AW | Slot 0 first source register |
| s0_rs2 | input | AW | Slot 0 second source register |
| s1_vld | input | 1 | Slot 1 holds an instruction |
| s1_wr | input | 1 | Slot 1 writes a destination |
| s1_dst | input | AW | Slot 1 destination register |
| s1_rs1 | input | AW | Slot 1 first source register |
| s1_rs2 | input | AW | Slot 1 second source register |
| out_valid | output | 1 | Renamed pair present on the outputs |
| r0_vld | output | 1 | Slot 0 result holds an instruction |
| r0_wr | output | 1 | Slot 0 was given a designator |
| r0_tag | output | TW | Slot 0 new destination designator |
| r0_ps1 | output | TW | Slot 0 renamed first source |
| r0_ps2 | output | TW | Slot 0 renamed second source |
| r1_vld | output | 1 | Slot 1 result holds an instruction |
| r1_wr | output | 1 | Slot 1 was given a designator |
| r1_tag | output | TW | Slot 1 new destination designator |
| r1_ps1 | output | TW | Slot 1 renamed first source |
| r1_ps2 | output | TW | Slot 1 renamed second source |

AW is the base-2 logarithm of ARCH_REGS and TW is that of TAG_COUNT. TAG_COUNT must be at least ARCH_REGS so that the reset identity values fit.

## Verification
The bench builds the block with its defaults: 32 registers, 64 designators, and a first designator of 9. That leaves 55 designators to hand out, so the exhaustion boundary comes within reach after fewer than thirty pairs. Pairs needing two, one and zero designators are then offered with exactly one designator, and then none, left. A reference map and pointer kept in the bench predict every renamed field, including bypass inside the pair and the same-register double write.

// File: rtl/rename2_pkg.sv
package rename2_pkg;

  localparam int DEF_ARCH_REGS = 32;
  localparam int DEF_TAG_COUNT = 64;
  localparam int DEF_FIRST_TAG = 9;
  localparam int SLOTS         = 2;
  localparam int SRCS_PER_SLOT = 2;

  // Number of designators a pair asks for.
  function automatic logic [1:0] pair_demand(input logic c0, input logic c1);
    return {1'b0, c0} + {1'b0, c1};
  endfunction

endpackage

// File: rtl/rename2_alloc.sv
module rename2_alloc
  import rename2_pkg::*;
#(
  parameter int TAG_COUNT = DEF_TAG_COUNT,
  parameter int FIRST_TAG = DEF_FIRST_TAG,
  parameter int TW        = $clog2(TAG_COUNT),
  parameter int PW        = $clog2(TAG_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          claim0,
  input  logic          claim1,
  input  logic          take,
  output logic          enough,
  output logic [TW-1:0] tag0,
  output logic [TW-1:0] tag1
);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] left;
  logic [PW-1:0] need;
  logic [PW-1:0] second;

  assign need   = PW'(pair_demand(claim0, claim1));
  assign left   = PW'(TAG_COUNT) - ptr_q;
  assign enough = (left >= need);
  assign second = ptr_q + PW'(claim0);
  assign tag0   = claim0 ? ptr_q[TW-1:0] : '0;
  assign tag1   = claim1 ? second[TW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= PW'(FIRST_TAG);
    end else if (take) begin
      ptr_q <= ptr_q + need;
    end
  end

endmodule

// File: rtl/rename2_map.sv
module rename2_map
  import rename2_pkg::*;
#(
  parameter int ARCH_REGS = DEF_ARCH_REGS,
  parameter int AW        = $clog2(ARCH_REGS),
  parameter int TW        = 6,
  parameter int RD_PORTS  = SLOTS * SRCS_PER_SLOT,
  parameter int WR_PORTS  = SLOTS
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [RD_PORTS-1:0][AW-1:0]  rd_addr,
  output logic [RD_PORTS-1:0][TW-1:0]  rd_data,
  input  logic [WR_PORTS-1:0]          wr_en,
  input  logic [WR_PORTS-1:0][AW-1:0]  wr_addr,
  input  logic [WR_PORTS-1:0][TW-1:0]  wr_data
);

  logic [TW-1:0] map_q [ARCH_REGS];

  genvar g;
  generate
    for (g = 0; g < RD_PORTS; g++) begin : g_rd
      assign rd_data[g] = map_q[rd_addr[g]];
    end
  endgenerate

  // Higher-numbered write ports are younger and win on a shared address.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_REGS; i++) begin
        map_q[i] <= TW'(i);
      end
    end else begin
      for (int w = 0; w < WR_PORTS; w++) begin
        if (wr_en[w]) begin
          map_q[wr_addr[w]] <= wr_data[w];
        end
      end
    end
  end

endmodule

// File: rtl/rename2_fwd.sv
module rename2_fwd #(
  parameter int AW = 5,
  parameter int TW = 6
) (
  input  logic          older_wr,
  input  logic [AW-1:0] older_dst,
  input  logic [TW-1:0] older_tag,
  input  logic [AW-1:0] src,
  input  logic [TW-1:0] table_tag,
  output logic [TW-1:0] tag
);

  always_comb begin
    if (older_wr && (older_dst == src)) begin
      tag = older_tag;
    end else begin
      tag = table_tag;
    end
  end

endmodule

// File: rtl/rename2_top.sv
module rename2_top
  import rename2_pkg::*;
#(
  parameter int ARCH_REGS = DEF_ARCH_REGS,
  parameter int TAG_COUNT = DEF_TAG_COUNT,
  parameter int FIRST_TAG = DEF_FIRST_TAG,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int TW = $clog2(TAG_COUNT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          s0_vld,
  input  logic          s0_wr,
  input  logic [AW-1:0] s0_dst,
  input  logic [AW-1:0] s0_rs1,
  input  logic [AW-1:0] s0_rs2,
  input  logic          s1_vld,
  input  logic          s1_wr,
  input  logic [AW-1:0] s1_dst,
  input  logic [AW-1:0] s1_rs1,
  input  logic [AW-1:0] s1_rs2,
  output logic          out_valid,
  output logic          r0_vld,
  output logic          r0_wr,
  output logic [TW-1:0] r0_tag,
  output logic [TW-1:0] r0_ps1,
  output logic [TW-1:0] r0_ps2,
  output logic          r1_vld,
  output logic          r1_wr,
  output logic [TW-1:0] r1_tag,
  output logic [TW-1:0] r1_ps1,
  output logic [TW-1:0] r1_ps2
);

  localparam int RDP = SLOTS * SRCS_PER_SLOT;

  logic                    claim0, claim1, take, enough;
  logic [TW-1:0]           tag0, tag1;
  logic [RDP-1:0][AW-1:0]  rd_addr;
  logic [RDP-1:0][TW-1:0]  rd_data;
  logic [SLOTS-1:0]        wr_en;
  logic [SLOTS-1:0][AW-1:0] wr_addr;
  logic [SLOTS-1:0][TW-1:0] wr_data;
  logic [SRCS_PER_SLOT-1:0][TW-1:0] young_src;

  assign claim0   = s0_vld & s0_wr;
  assign claim1   = s1_vld & s1_wr;
  assign in_ready = enough;
  assign take     = in_valid & enough;

  rename2_alloc #(
    .TAG_COUNT (TAG_COUNT),
    .FIRST_TAG (FIRST_TAG),
    .TW        (TW)
  ) alloc_i (
    .clk    (clk),
    .rst    (rst),
    .claim0 (claim0),
    .claim1 (claim1),
    .take   (take),
    .enough (enough),
    .tag0   (tag0),
    .tag1   (tag1)
  );

  assign rd_addr[0] = s0_rs1;
  assign rd_addr[1] = s0_rs2;
  assign rd_addr[2] = s1_rs1;
  assign rd_addr[3] = s1_rs2;

  assign wr_en[0]   = take & claim0;
  assign wr_en[1]   = take & claim1;
  assign wr_addr[0] = s0_dst;
  assign wr_addr[1] = s1_dst;
  assign wr_data[0] = tag0;
  assign wr_data[1] = tag1;

  rename2_map #(
    .ARCH_REGS (ARCH_REGS),
    .TW        (TW)
  ) map_i (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  // Younger slot sources look past the table at the older slot's new tag.
  genvar s;
  generate
    for (s = 0; s < SRCS_PER_SLOT; s++) begin : g_young
      rename2_fwd #(.AW(AW), .TW(TW)) fwd_i (
        .older_wr  (claim0),
        .older_dst (s0_dst),
        .older_tag (tag0),
        .src       (rd_addr[SRCS_PER_SLOT + s]),
        .table_tag (rd_data[SRCS_PER_SLOT + s]),
        .tag       (young_src[s])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      r0_vld    <= 1'b0;
      r0_wr     <= 1'b0;
      r0_tag    <= '0;
      r0_ps1    <= '0;
      r0_ps2    <= '0;
      r1_vld    <= 1'b0;
      r1_wr     <= 1'b0;
      r1_tag    <= '0;
      r1_ps1    <= '0;
      r1_ps2    <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        r0_vld <= s0_vld;
        r0_wr  <= claim0;
        r0_tag <= tag0;
        r0_ps1 <= rd_data[0];
        r0_ps2 <= rd_data[1];
        r1_vld <= s1_vld;
        r1_wr  <= claim1;
        r1_tag <= tag1;
        r1_ps1 <= young_src[0];
        r1_ps2 <= young_src[1];
      end
    end
  end

endmodule

// File: rtl/rename2_chk.sv
module rename2_chk #(
  parameter int AW = 5,
  parameter int TW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          s0_vld,
  input logic          s0_wr,
  input logic [AW-1:0] s0_dst,
  input logic          s1_vld,
  input logic          s1_wr,
  input logic [AW-1:0] s1_rs1,
  input logic [AW-1:0] s1_rs2,
  input logic          out_valid,
  input logic          r0_wr,
  input logic [TW-1:0] r0_tag,
  input logic          r1_wr,
  input logic [TW-1:0] r1_tag,
  input logic [TW-1:0] r1_ps1,
  input logic [TW-1:0] r1_ps2
);

  assert_accept_shows_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !out_valid);

  assert_pair_order_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && r0_wr && r1_wr) |-> (r1_tag == r0_tag + TW'(1)));

  assert_bypass_a_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && s0_vld && s0_wr && s1_vld && (s1_rs1 == s0_dst))
      |=> (r1_ps1 == r0_tag));

  assert_bypass_b_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && s0_vld && s0_wr && s1_vld && (s1_rs2 == s0_dst))
      |=> (r1_ps2 == r0_tag));

  assert_nodst_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (!(s0_vld && s0_wr) && !(s1_vld && s1_wr)) |-> in_ready);

  assert_nodst_tag_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !r0_wr) |-> (r0_tag == '0));

endmodule

bind rename2_top rename2_chk #(.AW(AW), .TW(TW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .s0_vld    (s0_vld),
  .s0_wr     (s0_wr),
  .s0_dst    (s0_dst),
  .s1_vld    (s1_vld),
  .s1_wr     (s1_wr),
  .s1_rs1    (s1_rs1),
  .s1_rs2    (s1_rs2),
  .out_valid (out_valid),
  .r0_wr     (r0_wr),
  .r0_tag    (r0_tag),
  .r1_wr     (r1_wr),
  .r1_tag    (r1_tag),
  .r1_ps1    (r1_ps1),
  .r1_ps2    (r1_ps2)
);

// File: tb/rename2_top_tb_top.sv
`timescale 1ns/1ps
module rename2_top_tb_top;

  localparam int AR = 32;
  localparam int TC = 64;
  localparam int FT = 9;
  localparam int AW = $clog2(AR);
  localparam int TW = $clog2(TC);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic s0_vld = 1'b0, s0_wr = 1'b0, s1_vld = 1'b0, s1_wr = 1'b0;
  logic [AW-1:0] s0_dst = '0, s0_rs1 = '0, s0_rs2 = '0;
  logic [AW-1:0] s1_dst = '0, s1_rs1 = '0, s1_rs2 = '0;
  logic out_valid, r0_vld, r0_wr, r1_vld, r1_wr;
  logic [TW-1:0] r0_tag, r0_ps1, r0_ps2, r1_tag, r1_ps1, r1_ps2;

  always #4 clk = ~clk;

  rename2_top #(.ARCH_REGS(AR), .TAG_COUNT(TC), .FIRST_TAG(FT)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .s0_vld(s0_vld), .s0_wr(s0_wr), .s0_dst(s0_dst), .s0_rs1(s0_rs1), .s0_rs2(s0_rs2),
    .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_dst(s1_dst), .s1_rs1(s1_rs1), .s1_rs2(s1_rs2),
    .out_valid(out_valid),
    .r0_vld(r0_vld), .r0_wr(r0_wr), .r0_tag(r0_tag), .r0_ps1(r0_ps1), .r0_ps2(r0_ps2),
    .r1_vld(r1_vld), .r1_wr(r1_wr), .r1_tag(r1_tag), .r1_ps1(r1_ps1), .r1_ps2(r1_ps2)
  );

  typedef struct {
    bit v0, w0; int t0, a0, b0;
    bit v1, w1; int t1, a1, b1;
    string req;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;
  int   mdl_map [AR];
  int   mdl_ptr;
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  // Driver: offers one pair for one cycle, predicts acceptance and result.
  task automatic send(input bit v0, input bit w0, input int d0, input int a0, input int b0,
                      input bit v1, input bit w1, input int d1, input int a1, input int b1,
                      input string req);
    exp_t e;
    int   need;
    bit   rdy;
    bit   c0, c1;
    @(negedge clk);
    s0_vld = v0; s0_wr = w0; s0_dst = AW'(d0); s0_rs1 = AW'(a0); s0_rs2 = AW'(b0);
    s1_vld = v1; s1_wr = w1; s1_dst = AW'(d1); s1_rs1 = AW'(a1); s1_rs2 = AW'(b1);
    in_valid = 1'b1;
    c0 = v0 && w0;
    c1 = v1 && w1;
    need = int'(c0) + int'(c1);
    rdy = (TC - mdl_ptr) >= need;
    #1;
    chk(in_ready == rdy, "R8 in_ready", int'(in_ready), int'(rdy));
    if (rdy) begin
      e.req = req;
      e.v0 = v0; e.w0 = c0; e.v1 = v1; e.w1 = c1;
      e.t0 = c0 ? mdl_ptr : 0;
      e.t1 = c1 ? mdl_ptr + int'(c0) : 0;
      e.a0 = mdl_map[a0];
      e.b0 = mdl_map[b0];
      e.a1 = (c0 && d0 == a1) ? e.t0 : mdl_map[a1];
      e.b1 = (c0 && d0 == b1) ? e.t0 : mdl_map[b1];
      if (c0) mdl_map[d0] = e.t0;
      if (c1) mdl_map[d1] = e.t1;
      mdl_ptr += need;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    if (rdy) exp_q.push_back(e);
  endtask

  // Monitor: compares registered outputs mid-cycle against the scoreboard.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (exp_q.size() == 0) begin
        chk(out_valid == 1'b0, "R2/R9 out_valid idle", int'(out_valid), 0);
      end else begin
        mon_e = exp_q.pop_front();
        chk(out_valid == 1'b1, "R2 out_valid", int'(out_valid), 1);
        chk(r0_vld == mon_e.v0, "R2 r0_vld", int'(r0_vld), int'(mon_e.v0));
        chk(r1_vld == mon_e.v1, "R2 r1_vld", int'(r1_vld), int'(mon_e.v1));
        chk(r0_wr == mon_e.w0, "R7 r0_wr", int'(r0_wr), int'(mon_e.w0));
        chk(r1_wr == mon_e.w1, "R7 r1_wr", int'(r1_wr), int'(mon_e.w1));
        chk(int'(r0_tag) == mon_e.t0, "R3 r0_tag", int'(r0_tag), mon_e.t0);
        chk(int'(r1_tag) == mon_e.t1, "R3 r1_tag", int'(r1_tag), mon_e.t1);
        if (mon_e.v0) begin
          chk(int'(r0_ps1) == mon_e.a0, {mon_e.req, " r0_ps1"}, int'(r0_ps1), mon_e.a0);
          chk(int'(r0_ps2) == mon_e.b0, {mon_e.req, " r0_ps2"}, int'(r0_ps2), mon_e.b0);
        end
        if (mon_e.v1) begin
          chk(int'(r1_ps1) == mon_e.a1, {mon_e.req, " r1_ps1"}, int'(r1_ps1), mon_e.a1);
          chk(int'(r1_ps2) == mon_e.b1, {mon_e.req, " r1_ps2"}, int'(r1_ps2), mon_e.b1);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    done = 1'b1;
    report();
  end

  initial begin
    for (int i = 0; i < AR; i++) mdl_map[i] = i;
    mdl_ptr = FT;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    s0_vld = 1'b1; s0_wr = 1'b1; s1_vld = 1'b1; s1_wr = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R1 identity reads, R3 first tags, R5 bypass on rs1
    send(1, 1, 1, 2, 3,   1, 1, 4, 1, 5,   "R1 R5");
    // R4 earlier mapping, R10 own-dst read, R5 bypass on rs2
    send(1, 1, 6, 6, 1,   1, 1, 0, 4, 6,   "R4 R10 R5");
    // R6 both write register 7
    send(1, 1, 7, 2, 2,   1, 1, 7, 3, 3,   "R6");
    send(1, 1, 8, 7, 7,   1, 0, 0, 7, 1,   "R6 R7");
    // R7 no destinations at all
    send(1, 0, 0, 1, 4,   1, 0, 0, 6, 7,   "R7");
    // R7 invalid older slot, R10 younger reads its own dst
    send(0, 1, 9, 0, 0,   1, 1, 5, 5, 8,   "R7 R10");
    // R9 idle cycles
    repeat (3) @(negedge clk);
    send(1, 1, 10, 8, 5,  1, 1, 11, 0, 7,  "R9 R4");

    // R3 R4 fill until one designator is left
    for (int k = 0; (TC - mdl_ptr) > 2; k++) begin
      send(1, 1, (k * 5 + 1) % AR, (k * 3) % AR, (k + 11) % AR,
           1, 1, (k * 7 + 2) % AR, (k * 5 + 1) % AR, (k * 13) % AR, "R3 R4");
    end
    if ((TC - mdl_ptr) == 2) send(1, 1, 12, 12, 13, 0, 0, 0, 0, 0, "R3");

    // R8 boundary: one left, pair wants two
    send(1, 1, 3, 3, 4,   1, 1, 9, 9, 10,  "R8");
    send(1, 1, 3, 7, 9,   0, 0, 0, 0, 0,   "R8 R4");
    // R8 none left
    send(1, 1, 2, 2, 3,   0, 0, 0, 0, 0,   "R8");
    send(0, 0, 0, 0, 0,   1, 1, 4, 4, 5,   "R8");
    send(1, 0, 0, 3, 7,   1, 0, 0, 2, 9,   "R7 R8");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    report();
  end

endmodule